// File: doc/BRIEF.md
# Signed Compare, Select and Maximum Execution Slice

This block is a single-cycle integer execution slice. It performs three operations on two 64-bit signed operands: a compare that records its outcome in a 32-bit condition register, a condition-driven select that picks one operand based on a single condition-register bit, and a fused maximum that compares and selects in the same operation. The condition register is divided into eight 4-bit fields, and each compare updates exactly one field.

One subtract-based comparator serves both compare and maximum. The operand sign bits are flipped so that an unsigned subtraction orders signed values correctly. Its carry-out indicates "first operand is at least the second" and drives the maximum multiplexer directly. A compare followed on the next cycle by a select on the greater-than bit of the same field therefore yields the same value as a fused maximum.

The slice accepts one operation per cycle when the valid strobe is high. Results, the result-valid flag and the condition register are all registered.

Top module: `cs_exec_unit`

## Requirements
- R1: While reset is asserted and immediately after it, `result` is 0, `result_valid` is 0 and `cond_reg` is 0.
- R2: `result_valid` is high in the cycle after an accepted operation with opcode 0 (compare), 1 (select) or 2 (maximum). In every other cycle it is low.
- R3: Opcode 2 returns the signed larger of `src_a` and `src_b`. When the two are equal it returns `src_a`.
- R4: Opcode 0 writes the field chosen by `field_sel` (field f occupies bits 4f+3..4f). Bit 4f+3 is set for less-than, bit 4f+2 for greater-than and bit 4f+1 for equal, all as signed comparisons of `src_a` against `src_b`, and exactly one of the three is set. `result` returns the new 4-bit field value, zero-extended.
- R5: A compare changes no field other than the addressed one, and it leaves bit 4f+0 of the addressed field unchanged.
- R6: Opcode 1 returns `src_a` when bit `bit_sel` (0..31) of `cond_reg` is 1, and `src_b` when that bit is 0.
- R7: A select issued in the cycle directly after a compare reads the condition bits that compare wrote.
- R8: Opcode 3, and any cycle with `in_valid` low, leaves `cond_reg` and `result` unchanged and raises no `result_valid`. Select and maximum never change `cond_reg`.
- R9: A compare into field f followed by a select on bit 4f+2 gives the same value as a maximum of the same operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| op | input | 2 | 0 compare, 1 select, 2 maximum, 3 reserved |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand |
| field_sel | input | 3 | Condition field written by a compare |
| bit_sel | input | 5 | Condition bit read by a select |
| result | output | 64 | Registered result |
| result_valid | output | 1 | High one cycle after an accepted operation |
| cond_reg | output | 32 | Condition register |

## Verification
A wrong comparator carry, such as an unsigned ordering or a missing sign flip, shows up one cycle after a maximum or a compare. It appears in `result` or in the flag field on `cond_reg`, and the operand sweep across the sign boundary exposes it at once. A field write to the wrong place, or one that disturbs the spare bit, becomes visible on `cond_reg` in the same cycle that `result_valid` rises. A condition register updated late shows up as a wrong select value on the back-to-back select that follows every compare.

// File: rtl/cs_pkg.sv
package cs_pkg;
    typedef enum logic [1:0] {
        OP_CMP  = 2'd0,
        OP_ISEL = 2'd1,
        OP_MAX  = 2'd2,
        OP_RSVD = 2'd3
    } op_e;

    // Flag positions counted down from the top of a field
    localparam int FLAG_CNT = 3;
endpackage

// File: rtl/cs_sub_compare.sv
// Signed ordering through an unsigned subtract with flipped sign bits.
module cs_sub_compare #(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         ge,
    output logic         eq
);
    logic [W-1:0] a_bias;
    logic [W-1:0] b_bias;
    logic [W:0]   diff;

    always_comb begin
        a_bias = {~a[W-1], a[W-2:0]};
        b_bias = {~b[W-1], b[W-2:0]};
        diff   = {1'b0, a_bias} + {1'b0, ~b_bias} + (W+1)'(1);
        ge     = diff[W];
        eq     = (diff[W-1:0] == '0);
    end
endmodule

// File: rtl/cs_cr_update.sv
// Next condition register for a compare into one field.
module cs_cr_update #(
    parameter int NF     = 8,
    parameter int FW     = 4,
    parameter int FIDX_W = 3
) (
    input  logic [NF*FW-1:0] cr_in,
    input  logic             wr_en,
    input  logic [FIDX_W-1:0] fidx,
    input  logic [2:0]       flags,
    output logic [NF*FW-1:0] cr_out,
    output logic [FW-1:0]    fld_new
);
    for (genvar f = 0; f < NF; f++) begin : g_field
        logic hit;
        assign hit = wr_en && (fidx == FIDX_W'(f));
        assign cr_out[f*FW +: FW] = hit ? {flags, cr_in[f*FW +: FW-3]}
                                        : cr_in[f*FW +: FW];
    end

    assign fld_new = cr_out[fidx*FW +: FW];
endmodule

// File: rtl/cs_isel_mux.sv
// Two-way operand select steered by one condition bit.
module cs_isel_mux #(
    parameter int W      = 64,
    parameter int N      = 32,
    parameter int BIDX_W = 5
) (
    input  logic [N-1:0]      cr,
    input  logic [BIDX_W-1:0] bidx,
    input  logic [W-1:0]      a,
    input  logic [W-1:0]      b,
    output logic [W-1:0]      y
);
    logic sel_bit;
    assign sel_bit = cr[bidx];
    assign y       = sel_bit ? a : b;
endmodule

// File: rtl/cs_exec_unit.sv
module cs_exec_unit #(
    parameter int DATA_W = 64,
    parameter int NF     = 8,
    parameter int FW     = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [1:0]                    op,
    input  logic [DATA_W-1:0]             src_a,
    input  logic [DATA_W-1:0]             src_b,
    input  logic [$clog2(NF)-1:0]         field_sel,
    input  logic [$clog2(NF*FW)-1:0]      bit_sel,
    output logic [DATA_W-1:0]             result,
    output logic                          result_valid,
    output logic [NF*FW-1:0]              cond_reg
);
    import cs_pkg::*;

    localparam int CR_W   = NF * FW;
    localparam int FIDX_W = $clog2(NF);
    localparam int BIDX_W = $clog2(CR_W);

    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic              res_valid;
        logic [CR_W-1:0]   cr;
    } state_t;

    state_t st_d, st_q;

    logic              a_ge_b;
    logic              a_eq_b;
    logic [2:0]        flags;
    logic              is_cmp;
    logic [CR_W-1:0]   cr_cmp;
    logic [FW-1:0]     fld_new;
    logic [DATA_W-1:0] isel_y;
    logic [DATA_W-1:0] max_y;
    op_e               op_t;

    assign op_t   = op_e'(op);
    assign is_cmp = in_valid && (op_t == OP_CMP);
    // less-than, greater-than, equal
    assign flags  = {~a_ge_b, a_ge_b & ~a_eq_b, a_eq_b};
    assign max_y  = a_ge_b ? src_a : src_b;

    cs_sub_compare #(.W(DATA_W)) u_cmp (
        .a  (src_a),
        .b  (src_b),
        .ge (a_ge_b),
        .eq (a_eq_b)
    );

    cs_cr_update #(.NF(NF), .FW(FW), .FIDX_W(FIDX_W)) u_cru (
        .cr_in   (st_q.cr),
        .wr_en   (is_cmp),
        .fidx    (field_sel),
        .flags   (flags),
        .cr_out  (cr_cmp),
        .fld_new (fld_new)
    );

    cs_isel_mux #(.W(DATA_W), .N(CR_W), .BIDX_W(BIDX_W)) u_isel (
        .cr   (st_q.cr),
        .bidx (bit_sel),
        .a    (src_a),
        .b    (src_b),
        .y    (isel_y)
    );

    always_comb begin
        st_d           = st_q;
        st_d.res_valid = 1'b0;
        if (in_valid) begin
            unique case (op_t)
                OP_CMP: begin
                    st_d.cr        = cr_cmp;
                    st_d.result    = {{(DATA_W-FW){1'b0}}, fld_new};
                    st_d.res_valid = 1'b1;
                end
                OP_ISEL: begin
                    st_d.result    = isel_y;
                    st_d.res_valid = 1'b1;
                end
                OP_MAX: begin
                    st_d.result    = max_y;
                    st_d.res_valid = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result       = st_q.result;
    assign result_valid = st_q.res_valid;
    assign cond_reg     = st_q.cr;
endmodule

// File: rtl/cs_unit_chk.sv
module cs_unit_chk #(
    parameter int DATA_W = 64,
    parameter int NF     = 8,
    parameter int FW     = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic [1:0]               op,
    input logic [DATA_W-1:0]        src_a,
    input logic [DATA_W-1:0]        src_b,
    input logic [$clog2(NF)-1:0]    field_sel,
    input logic [$clog2(NF*FW)-1:0] bit_sel,
    input logic [DATA_W-1:0]        result,
    input logic                     result_valid,
    input logic [NF*FW-1:0]         cond_reg
);
    function automatic logic [NF*FW-1:0] spare_mask();
        logic [NF*FW-1:0] m = '0;
        for (int f = 0; f < NF; f++) m[f*FW] = 1'b1;
        return m;
    endfunction

    localparam logic [NF*FW-1:0] SPARE = spare_mask();

    // R2
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op != 2'd3) |=> result_valid);
    a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && op != 2'd3) |=> !result_valid);
    // R3
    a_r3_max_is_larger: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'd2) |=>
        ($signed(result) >= $signed($past(src_a)) && $signed(result) >= $signed($past(src_b))));
    // R4
    a_r4_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'd0) |=> ($countones(result[FW-1:FW-3]) == 1));
    a_r4_field_matches_result: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'd0) |=> (cond_reg[$past(field_sel)*FW +: FW] == result[FW-1:0]));
    // R5
    a_r5_spare_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(cond_reg & SPARE));
    // R6
    a_r6_isel_pick: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'd1) |=>
        (result == ($past(cond_reg[bit_sel]) ? $past(src_a) : $past(src_b))));
    // R8
    a_r8_cr_only_by_compare: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && op == 2'd0) |=> $stable(cond_reg));
endmodule

bind cs_exec_unit cs_unit_chk #(.DATA_W(DATA_W), .NF(NF), .FW(FW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .op           (op),
    .src_a        (src_a),
    .src_b        (src_b),
    .field_sel    (field_sel),
    .bit_sel      (bit_sel),
    .result       (result),
    .result_valid (result_valid),
    .cond_reg     (cond_reg)
);

// File: tb/cs_exec_unit_test.sv
module cs_exec_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op = 2'd0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic [2:0]  field_sel = '0;
    logic [4:0]  bit_sel = '0;
    logic [63:0] result;
    logic        result_valid;
    logic [31:0] cond_reg;

    int tests = 0;
    int fails = 0;
    logic [31:0] model_cr = '0;
    logic [63:0] vals [0:7];

    always #(CLK_PERIOD/2) clk = ~clk;

    cs_exec_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .src_a(src_a), .src_b(src_b), .field_sel(field_sel), .bit_sel(bit_sel),
        .result(result), .result_valid(result_valid), .cond_reg(cond_reg)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic v, input logic [1:0] o, input logic [63:0] a,
                         input logic [63:0] b, input logic [2:0] f, input logic [4:0] k);
        in_valid = v; op = o; src_a = a; src_b = b; field_sel = f; bit_sel = k;
        @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        vals[0] = 64'd0;
        vals[1] = 64'd1;
        vals[2] = 64'hFFFF_FFFF_FFFF_FFFF;
        vals[3] = 64'h7FFF_FFFF_FFFF_FFFF;
        vals[4] = 64'h8000_0000_0000_0000;
        vals[5] = 64'd1234567;
        vals[6] = 64'hFFFF_FFFF_FFFF_FF00;
        vals[7] = 64'h0000_0001_0000_0000;

        repeat (3) @(negedge clk);
        chk("R1 result", result, 64'd0);
        chk("R1 valid", {63'd0, result_valid}, 64'd0);
        chk("R1 cond_reg", {32'd0, cond_reg}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {32'd0, cond_reg}, 64'd0);

        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                logic [63:0] a, b, mx;
                logic [2:0] f;
                logic lt, gt, eq;
                a  = vals[i];
                b  = vals[j];
                f  = 3'((i + j) % 8);
                lt = $signed(a) < $signed(b);
                gt = $signed(a) > $signed(b);
                eq = (a == b);
                mx = ($signed(a) >= $signed(b)) ? a : b;
                model_cr[f*4 +: 4] = {lt, gt, eq, model_cr[f*4]};

                issue(1'b1, 2'd0, a, b, f, 5'd0);
                chk("R4 compare field", result, {60'd0, lt, gt, eq, model_cr[f*4]});
                chk("R5 cond_reg", {32'd0, cond_reg}, {32'd0, model_cr});
                chk("R2 valid after compare", {63'd0, result_valid}, 64'd1);

                // back-to-back select on the greater-than bit just written
                issue(1'b1, 2'd1, a, b, 3'd0, 5'(f*4 + 2));
                chk("R7 R9 select after compare", result, mx);

                issue(1'b1, 2'd2, a, b, 3'd0, 5'd0);
                chk("R3 max", result, mx);
                chk("R8 max leaves cond_reg", {32'd0, cond_reg}, {32'd0, model_cr});
            end
        end

        for (int k = 0; k < 32; k++) begin
            logic [63:0] a, b;
            a = 64'(k) + 64'd100;
            b = ~64'(k);
            issue(1'b1, 2'd1, a, b, 3'd0, 5'(k));
            chk("R6 select bit", result, model_cr[k] ? a : b);
        end

        begin
            logic [63:0] held;
            held = result;
            issue(1'b1, 2'd3, 64'd5, 64'd9, 3'd1, 5'd0);
            chk("R8 reserved no valid", {63'd0, result_valid}, 64'd0);
            chk("R8 reserved holds result", result, held);
            chk("R8 reserved cond_reg", {32'd0, cond_reg}, {32'd0, model_cr});
            issue(1'b0, 2'd0, 64'd5, 64'd9, 3'd2, 5'd0);
            chk("R8 idle compare no valid", {63'd0, result_valid}, 64'd0);
            chk("R8 idle compare cond_reg", {32'd0, cond_reg}, {32'd0, model_cr});
            chk("R2 idle holds result", result, held);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule